// File: doc/BRIEF.md
# External Bus Area Controller

This block sits between one internal bus master and an external asynchronous memory bus. The external address space is split into eight equal areas, each 2 Mbytes wide. For each access the block decodes the area from the address bits directly above the 21-bit offset and drives that area's active-low chip select. It then sequences the read strobe or the byte write strobes, and returns a one-cycle done pulse to the master. Each area holds its own bus width (8 or 16 bits), basic cycle length (2 or 3 states) and program wait count (0 to 7). A small configuration port writes these settings one area at a time.

The master raises `req` for one cycle while the controller is idle, with `addr`, `we`, `word` and `wdata` valid. It then waits for `done`. Read data is valid on `rdata` while `done` is high. Byte data travels in `wdata[7:0]` and `rdata[7:0]`. For a word, the byte at the even address is the upper byte `[15:8]`. A word access to an 8-bit area runs as two byte cycles, the even address first and then the odd address. The chip select stays low across both cycles.

The state machine has five states. IDLE holds all selects high and accepts a request (IDLE→T1). T1 is the address state (T1→T2). T2 either ends a 2-state cycle or, in 3-state mode, moves on to TW when the wait count is not zero (T2→TW) and otherwise to T3 (T2→T3). TW counts wait states (TW→TW) and then moves to T3 (TW→T3). The last state of a byte cycle either starts the second byte of a split word (T2→T1 or T3→T1) or ends the access (T2→IDLE or T3→IDLE).

Top module: `ext_area_ctrl`

## Requirements
- R1: During an access exactly one chip select is low: bit k of `cs_n`, where k = `addr[23:21]`. In IDLE all eight are high.
- R2: The chip select stays constant and low for the whole access, including wait states and both halves of a split word. It is high in the cycle in which `done` is asserted, so at least one idle state separates two accesses.
- R3: An area set to 2-state mode holds its select low for exactly 2 cycles per byte cycle. Its wait count has no effect.
- R4: An area set to 3-state mode holds its select low for 3 + W cycles per byte cycle, where W is that area's 3-bit wait count.
- R5: A configuration write (`cfg_we` with `cfg_sel` = area) changes only the settings of that area.
- R6: After reset every area is 16-bit wide, 3-state, with W = 7, so a word access takes 10 select-low cycles.
- R7: A word access to a 16-bit area is one byte cycle with `ext_addr[0]` = 0. It drives both write strobes, and `rdata` equals `ext_rdata`.
- R8: A byte access to a 16-bit area uses the upper lane `[15:8]` with `wrh_n` at an even address, and the lower lane `[7:0]` with `wrl_n` at an odd address. The read byte is returned in `rdata[7:0]` with `rdata[15:8]` = 0.
- R9: A word access to an 8-bit area runs two byte cycles: `ext_addr[0]` = 0, then 1. Both cycles use the upper lane and `wrh_n`. `rdata` = {even byte, odd byte}, and `done` comes only after the second cycle.
- R10: A byte access to an 8-bit area is a single byte cycle on the upper lane. `wrl_n` never goes low for an 8-bit area.
- R11: `rd_n` is low for every select-low cycle of a read. On a write, the write strobes are low in every select-low cycle except the first of each byte cycle. Read and write strobes are never low together, and neither is low while all selects are high.
- R12: `done` is a one-cycle pulse. It arrives in the cycle after the last state of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled in IDLE |
| addr | input | 24 | Byte address of the access |
| we | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit access (addr[0] ignored), 0 = byte |
| wdata | input | 16 | Write data (byte in [7:0]) |
| rdata | output | 16 | Read data, valid with done |
| done | output | 1 | Access complete pulse |
| cfg_we | input | 1 | Write one area's settings |
| cfg_sel | input | 3 | Area being configured |
| cfg_wide | input | 1 | 1 = 16-bit area, 0 = 8-bit area |
| cfg_three | input | 1 | 1 = 3-state cycle, 0 = 2-state cycle |
| cfg_waits | input | 3 | Wait states inserted in 3-state mode |
| ext_addr | output | 24 | External address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| cs_n | output | 8 | Active-low chip select per area |
| rd_n | output | 1 | Active-low read strobe |
| wrh_n | output | 1 | Active-low write strobe, upper lane |
| wrl_n | output | 1 | Active-low write strobe, lower lane |

## Verification
A wrong state or a wrong latched area setting shows up at the pins within the access in which it occurs. A bad wait counter or a wrong cycle-mode bit changes the number of select-low cycles and moves the `done` pulse. A wrong split flag changes the sequence of `ext_addr[0]` values or the packed `rdata`. A lost area register shows up on the next access to that area as a wrong cycle count or a wrong lane. Each access is therefore checked for cycle count, select pattern, address sequence, strobe counts, write bytes and returned data.

// File: rtl/ext_area_pkg.sv
package ext_area_pkg;

    localparam int WAIT_W = 3;
    localparam int BYTE_W = 8;
    localparam int DATA_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3
    } bus_state_e;

    typedef struct packed {
        logic              wide;
        logic              three;
        logic [WAIT_W-1:0] waits;
    } area_cfg_t;

endpackage

// File: rtl/ext_area_cfg.sv
module ext_area_cfg
    import ext_area_pkg::*;
#(
    parameter int AREA_BITS = 3,
    localparam int NUM_AREAS = 1 << AREA_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AREA_BITS-1:0] wr_sel,
    input  area_cfg_t            wr_cfg,
    input  logic [AREA_BITS-1:0] rd_sel,
    output area_cfg_t            rd_cfg
);

    area_cfg_t regs [NUM_AREAS];

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '{wide: 1'b1, three: 1'b1, waits: '1};
            end else if (wr_en && wr_sel == AREA_BITS'(g)) begin
                regs[g] <= wr_cfg;
            end
        end
    end

    assign rd_cfg = regs[rd_sel];

endmodule

// File: rtl/ext_area_decode.sv
module ext_area_decode #(
    parameter int OFFSET_W  = 21,
    parameter int AREA_BITS = 3,
    localparam int ADDR_W    = OFFSET_W + AREA_BITS,
    localparam int NUM_AREAS = 1 << AREA_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_AREAS-1:0] sel
);

    logic [AREA_BITS-1:0] area;
    assign area = addr[ADDR_W-1 -: AREA_BITS];

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_sel
        assign sel[g] = (area == AREA_BITS'(g));
    end

endmodule

// File: rtl/ext_area_ctrl.sv
module ext_area_ctrl
    import ext_area_pkg::*;
#(
    parameter int OFFSET_W  = 21,
    parameter int AREA_BITS = 3,
    localparam int ADDR_W    = OFFSET_W + AREA_BITS,
    localparam int NUM_AREAS = 1 << AREA_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    input  logic                 word,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 done,
    input  logic                 cfg_we,
    input  logic [AREA_BITS-1:0] cfg_sel,
    input  logic                 cfg_wide,
    input  logic                 cfg_three,
    input  logic [WAIT_W-1:0]    cfg_waits,
    output logic [ADDR_W-1:0]    ext_addr,
    output logic [DATA_W-1:0]    ext_wdata,
    input  logic [DATA_W-1:0]    ext_rdata,
    output logic [NUM_AREAS-1:0] cs_n,
    output logic                 rd_n,
    output logic                 wrh_n,
    output logic                 wrl_n
);

    bus_state_e state, nxt;

    logic [ADDR_W-1:0]    addr_q;
    logic                 we_q, word_q, second_q;
    logic [DATA_W-1:0]    wdata_q, rdata_q;
    logic [BYTE_W-1:0]    hi_q;
    logic [WAIT_W-1:0]    wcnt;
    logic                 done_q;
    area_cfg_t            cfg_q, cfg_rd;
    logic [NUM_AREAS-1:0] sel;

    ext_area_cfg #(.AREA_BITS(AREA_BITS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_sel (cfg_sel),
        .wr_cfg ('{wide: cfg_wide, three: cfg_three, waits: cfg_waits}),
        .rd_sel (addr[ADDR_W-1 -: AREA_BITS]),
        .rd_cfg (cfg_rd)
    );

    ext_area_decode #(.OFFSET_W(OFFSET_W), .AREA_BITS(AREA_BITS)) u_dec (
        .addr (addr_q),
        .sel  (sel)
    );

    // Which half of the access the external bus carries now
    logic             split, last_st, more, cur_a0;
    logic [BYTE_W-1:0] rbyte, wbyte;

    assign split   = word_q && !cfg_q.wide;
    assign last_st = (state == ST_T2 && !cfg_q.three) || state == ST_T3;
    assign more    = last_st && split && !second_q;
    assign cur_a0  = word_q ? second_q : addr_q[0];
    assign rbyte   = (cfg_q.wide && cur_a0) ? ext_rdata[BYTE_W-1:0]
                                            : ext_rdata[DATA_W-1:BYTE_W];
    assign wbyte   = (word_q && !second_q) ? wdata_q[DATA_W-1:BYTE_W]
                                           : wdata_q[BYTE_W-1:0];

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req) nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2: begin
                if (!cfg_q.three)            nxt = more ? ST_T1 : ST_IDLE;
                else if (cfg_q.waits != '0)  nxt = ST_TW;
                else                         nxt = ST_T3;
            end
            ST_TW:   if (WAIT_W'(wcnt + 1'b1) == cfg_q.waits) nxt = ST_T3;
            ST_T3:   nxt = more ? ST_T1 : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and access context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            we_q     <= 1'b0;
            word_q   <= 1'b0;
            second_q <= 1'b0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            hi_q     <= '0;
            wcnt     <= '0;
            done_q   <= 1'b0;
            cfg_q    <= '{wide: 1'b1, three: 1'b1, waits: '1};
        end else begin
            state  <= nxt;
            done_q <= last_st && !more;
            if (state == ST_IDLE && req) begin
                addr_q   <= addr;
                we_q     <= we;
                word_q   <= word;
                wdata_q  <= wdata;
                cfg_q    <= cfg_rd;
                second_q <= 1'b0;
            end
            if (state == ST_T2) wcnt <= '0;
            if (state == ST_TW) wcnt <= WAIT_W'(wcnt + 1'b1);
            if (more) second_q <= 1'b1;
            if (last_st && !we_q) begin
                if (word_q && cfg_q.wide)  rdata_q <= ext_rdata;
                else if (word_q && !second_q) hi_q <= rbyte;
                else if (word_q)           rdata_q <= {hi_q, rbyte};
                else                       rdata_q <= {{BYTE_W{1'b0}}, rbyte};
            end
        end
    end

    // Output decode
    logic active, wphase, hi_en, lo_en;
    always_comb begin
        active = (state != ST_IDLE);
        wphase = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
        if (!cfg_q.wide) begin
            hi_en = 1'b1;
            lo_en = 1'b0;
        end else if (word_q) begin
            hi_en = 1'b1;
            lo_en = 1'b1;
        end else begin
            hi_en = !addr_q[0];
            lo_en = addr_q[0];
        end
        cs_n      = active ? ~sel : '1;
        rd_n      = !(active && !we_q);
        wrh_n     = !(wphase && we_q && hi_en);
        wrl_n     = !(wphase && we_q && lo_en);
        ext_addr  = {addr_q[ADDR_W-1:1], cur_a0};
        ext_wdata = (cfg_q.wide && word_q) ? wdata_q : {wbyte, wbyte};
    end

    assign rdata = rdata_q;
    assign done  = done_q;

endmodule

// File: rtl/ext_area_chk.sv
module ext_area_chk #(
    parameter int NUM_AREAS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_AREAS-1:0] cs_n,
    input logic                 rd_n,
    input logic                 wrh_n,
    input logic                 wrl_n,
    input logic                 done
);

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1 && $past(cs_n) != '1) |-> cs_n == $past(cs_n));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n == '1);

    // R11
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wrh_n || !wrl_n) |-> cs_n != '1);

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && (!wrh_n || !wrl_n)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cs_n) != '1);

endmodule

bind ext_area_ctrl ext_area_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .rd_n  (rd_n),
    .wrh_n (wrh_n),
    .wrl_n (wrl_n),
    .done  (done)
);

// File: tb/sim_ext_area_ctrl.sv
module sim_ext_area_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, word = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        done;
    logic        cfg_we = 1'b0, cfg_wide = 1'b0, cfg_three = 1'b0;
    logic [2:0]  cfg_sel = '0, cfg_waits = '0;
    logic [23:0] ext_addr;
    logic [15:0] ext_wdata, ext_rdata;
    logic [7:0]  cs_n;
    logic        rd_n, wrh_n, wrl_n;

    int n_chk = 0, n_bad = 0;

    // Bench model of per-area settings
    logic       m_wide [8];
    logic       m_three[8];
    logic [2:0] m_wait [8];

    always #4 clk = ~clk;

    ext_area_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we), .word(word),
        .wdata(wdata), .rdata(rdata), .done(done), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wide(cfg_wide), .cfg_three(cfg_three),
        .cfg_waits(cfg_waits), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .cs_n(cs_n), .rd_n(rd_n), .wrh_n(wrh_n),
        .wrl_n(wrl_n)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[23:21], 5'h15};
    endfunction

    // External memory: 16-bit areas answer both lanes, 8-bit areas the upper lane
    always_comb begin
        if (m_wide[ext_addr[23:21]])
            ext_rdata = {mem_byte({ext_addr[23:1], 1'b0}), mem_byte({ext_addr[23:1], 1'b1})};
        else
            ext_rdata = {mem_byte(ext_addr), ~mem_byte(ext_addr)};
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Port monitor for the current access
    int          mon_cyc, mon_rd, mon_wr, mon_wrbad, mon_csbad, mon_an, wn;
    logic [7:0]  mon_cs_exp;
    logic [23:0] mon_first, mon_last;
    logic [23:0] wa[2];
    logic [7:0]  wd[2];

    task automatic log_wr(input logic [23:0] a, input logic [7:0] d);
        for (int i = 0; i < 2; i++)
            if (i < wn && wa[i] == a) begin
                wd[i] = d;
                return;
            end
        if (wn < 2) begin
            wa[wn] = a;
            wd[wn] = d;
            wn++;
        end else mon_wrbad++;
    endtask

    always @(negedge clk) begin
        if (cs_n != 8'hFF) begin
            mon_cyc++;
            if (cs_n != ~mon_cs_exp) mon_csbad++;
            if (mon_an == 0) mon_first = ext_addr;
            mon_an++;
            mon_last = ext_addr;
            if (!rd_n) mon_rd++;
            if (!wrh_n || !wrl_n) mon_wr++;
            if (!wrh_n) begin
                if (m_wide[ext_addr[23:21]]) log_wr({ext_addr[23:1], 1'b0}, ext_wdata[15:8]);
                else log_wr(ext_addr, ext_wdata[15:8]);
            end
            if (!wrl_n) begin
                if (!m_wide[ext_addr[23:21]]) mon_wrbad++;
                log_wr({ext_addr[23:1], 1'b1}, ext_wdata[7:0]);
            end
        end
    end

    task automatic set_cfg(input logic [2:0] ar, input bit wide, input bit three, input logic [2:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = ar; cfg_wide = wide; cfg_three = three; cfg_waits = w;
        @(negedge clk);
        cfg_we = 1'b0;
        m_wide[ar] = wide; m_three[ar] = three; m_wait[ar] = w;
    endtask

    task automatic access(input logic [23:0] a, input bit w, input bit wd16,
                          input logic [15:0] dat, input string rq);
        logic [2:0]  ar;
        int          len, nbc, t;
        logic [23:0] ev, od;
        logic [15:0] exp_rd;
        ar  = a[23:21];
        len = m_three[ar] ? 3 + int'(m_wait[ar]) : 2;
        nbc = (wd16 && !m_wide[ar]) ? 2 : 1;
        ev  = {a[23:1], 1'b0};
        od  = {a[23:1], 1'b1};
        @(negedge clk);
        mon_cyc = 0; mon_rd = 0; mon_wr = 0; mon_wrbad = 0; mon_csbad = 0;
        mon_an = 0; wn = 0; mon_cs_exp = 8'd1 << ar;
        req = 1'b1; addr = a; we = w; word = wd16; wdata = dat;
        @(negedge clk);
        req = 1'b0;
        t = 0;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
        end
        // R12 done latency / R3 R4 select-low count
        chk(t == nbc * len, {rq, " R12 done latency"}, t, nbc * len);
        chk(mon_cyc == nbc * len, {rq, " R3/R4 select cycles"}, mon_cyc, nbc * len);
        // R1 select pattern
        chk(mon_csbad == 0, {rq, " R1 chip select"}, mon_csbad, 0);
        // R2 idle state with done
        chk(cs_n == 8'hFF, {rq, " R2 idle at done"}, cs_n, 8'hFF);
        if (wd16) begin
            chk(mon_first == ev, {rq, " R7/R9 first address"}, mon_first, ev);
            chk(mon_last == (nbc == 2 ? od : ev), {rq, " R9 last address"}, mon_last, nbc == 2 ? od : ev);
        end else begin
            chk(mon_first == a && mon_last == a, {rq, " R8/R10 byte address"}, mon_last, a);
        end
        if (!w) begin
            exp_rd = wd16 ? {mem_byte(ev), mem_byte(od)} : {8'h00, mem_byte(a)};
            chk(rdata == exp_rd, {rq, " R7/R8/R9 read data"}, rdata, exp_rd);
            chk(mon_rd == nbc * len && mon_wr == 0, {rq, " R11 read strobe"}, mon_rd, nbc * len);
        end else begin
            chk(mon_wr == nbc * (len - 1) && mon_rd == 0, {rq, " R11 write strobe"}, mon_wr, nbc * (len - 1));
            chk(mon_wrbad == 0, {rq, " R10 lane"}, mon_wrbad, 0);
            if (wd16) begin
                chk(wn == 2 && wa[0] == ev && wd[0] == dat[15:8] && wa[1] == od && wd[1] == dat[7:0],
                    {rq, " R7/R9 write bytes"}, {wd[0], wd[1]}, dat);
            end else begin
                chk(wn == 1 && wa[0] == a && wd[0] == dat[7:0],
                    {rq, " R8/R10 write byte"}, {wa[0], wd[0]}, {a, dat[7:0]});
            end
        end
        @(negedge clk);
        chk(done == 1'b0, {rq, " R12 done pulse width"}, done, 0);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) begin
            m_wide[i] = 1'b1; m_three[i] = 1'b1; m_wait[i] = 3'd7;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R11 R12 reset state
        chk(cs_n == 8'hFF && rd_n && wrh_n && wrl_n && !done, "R1 reset outputs",
            {cs_n, rd_n, wrh_n, wrl_n, done}, {8'hFF, 4'b1110});
        // R6 defaults: 16-bit, 3-state, 7 waits
        access({3'd3, 21'h01_2345}, 1'b0, 1'b1, 16'h0, "R6 default word read");
        access({3'd7, 21'h0A_BCD0}, 1'b1, 1'b1, 16'hBEEF, "R6 default word write");
        // R3 2-state 8-bit area, waits ignored
        set_cfg(3'd0, 1'b0, 1'b0, 3'd5);
        access({3'd0, 21'h00_1000}, 1'b0, 1'b1, 16'h0, "R9 R3 split read");
        access({3'd0, 21'h00_1003}, 1'b1, 1'b1, 16'hA55A, "R9 split write odd addr");
        access({3'd0, 21'h00_0777}, 1'b0, 1'b0, 16'h0, "R10 narrow byte read");
        access({3'd0, 21'h00_0778}, 1'b1, 1'b0, 16'h00C3, "R10 narrow byte write");
        // R4 3-state, zero waits, 16-bit
        set_cfg(3'd1, 1'b1, 1'b1, 3'd0);
        access({3'd1, 21'h1F_FFFF}, 1'b1, 1'b0, 16'h003C, "R8 odd byte write");
        access({3'd1, 21'h1F_FFFE}, 1'b1, 1'b0, 16'h0081, "R8 even byte write");
        access({3'd1, 21'h00_0011}, 1'b0, 1'b0, 16'h0, "R8 odd byte read");
        // R5 neighbour areas keep defaults
        access({3'd2, 21'h00_0000}, 1'b0, 1'b1, 16'h0, "R5 untouched area");
        // R4 3-state narrow with waits
        set_cfg(3'd5, 1'b0, 1'b1, 3'd2);
        access({3'd5, 21'h12_3456}, 1'b0, 1'b1, 16'h0, "R4 narrow 3-state waits");
        access({3'd4, 21'h12_3456}, 1'b0, 1'b1, 16'h0, "R5 area 4 default");
        // Constrained random mix
        for (int k = 0; k < 60; k++) begin
            if (k % 6 == 0)
                set_cfg(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 3'($urandom));
            access(24'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), "R1 R4 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule